// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Channel

This block takes a snapshot of a free-running time base when an external, asynchronous signal makes a chosen transition. Software arms the channel with a one-cycle write strobe. The next qualifying edge on the capture input then stores the low bits of the time window and raises a status flag. After that, the channel disarms itself. Further edges are ignored until software arms it again, and the stored timestamp is held until the next capture.

The capture input is brought into the clock domain through a synchronizer chain. An edge is detected by comparing the synchronized level with its value one cycle earlier. A configuration strobe selects either rising or falling edges. The status flag stays set until software writes its clear strobe or reads the captured value through the read strobe. The flag is ANDed with a mask to form the interrupt. The mask has its own set and clear strobes.

Top module: `tstamp_capture`

## Requirements
- R1: After reset the captured value is 0, the status flag and the interrupt are 0, the mask is 0, the edge select is rising, and the channel is unarmed: an edge seen before the first arm causes no capture.
- R2: While armed, a qualifying edge stores bits [CAP_W-1:0] of `time_lo`. The value stored is the one present during the cycle before the third rising clock edge after the input changes: two synchronizer flops plus one cycle of edge detection.
- R3: With edge select 0 (written through `cfg_wr` with `cfg_edge`=0), only a 0-to-1 transition of `cap_in` captures. A falling transition is ignored.
- R4: With edge select 1, only a 1-to-0 transition captures. A rising transition is ignored.
- R5: A capture disarms the channel. Later edges neither change the captured value nor set the status until `arm_set` is pulsed again.
- R6: A pulse on `arm_clr` unarms the channel without setting the status, so a following edge is not captured.
- R7: If `arm_clr` coincides with the cycle in which a capture fires, the capture still happens: the value is stored and the status is set.
- R8: A capture sets `stat_raw` one cycle later, and the flag stays set until it is cleared.
- R9: A pulse on `stat_clr` clears `stat_raw` on the next cycle.
- R10: A pulse on `cap_rd` clears `stat_raw` on the next cycle and leaves the captured value unchanged.
- R11: When a capture coincides with `cap_rd` or `stat_clr`, the capture wins: `stat_raw` ends up 1 and the new value is stored.
- R12: `irq` equals `stat_raw` AND the mask. `mask_set` sets the mask and `mask_clr` clears it. When both are pulsed in the same cycle, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture signal |
| time_lo | input | TIME_W | Low window of the external time counter |
| arm_set | input | 1 | Arm strobe (write 1) |
| arm_clr | input | 1 | Disarm strobe (write 1) |
| cfg_wr | input | 1 | Edge-select write strobe |
| cfg_edge | input | 1 | Edge select data: 0 rising, 1 falling |
| stat_clr | input | 1 | Status clear strobe (write 1) |
| mask_set | input | 1 | Mask set strobe (write 1) |
| mask_clr | input | 1 | Mask clear strobe (write 1) |
| cap_rd | input | 1 | Read strobe for the captured value |
| cap_val | output | CAP_W | Captured timestamp |
| stat_raw | output | 1 | Raw capture status flag |
| irq | output | 1 | Masked interrupt |

## Verification
Two pairs of functions can collide. A capture can coincide with the software strobes that undo state: a disarm, a status clear, or a read of the captured value. The bench finds the cycle in which the synchronized edge is acted on and pulses every combination of these three strobes in exactly that cycle. It judges each result by two things: the status must end up set and the stored value must match the time window sampled in that cycle. A follow-up edge must then be ignored, which shows that the self-disarm happened regardless of the strobes. The same-cycle set and clear of the mask is also provoked, and set must win.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TIME_W_DEF = 32;
    localparam int CAP_W_DEF  = 21;
    localparam int SYNC_DEF   = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic logic edge_match(edge_sel_e sel, edge_evt_t ev);
        return (sel == EDGE_FALL) ? ev.fall : ev.rise;
    endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync
    import tsc_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_in,
    output edge_evt_t evt
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= level;
    end

    always_comb begin
        evt.rise = level & ~last_q;
        evt.fall = ~level & last_q;
    end

    // An edge indication lasts a single cycle (R3, R4)
    p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> !evt.rise);
    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> !evt.fall);

endmodule

// File: rtl/tsc_arm.sv
module tsc_arm
    import tsc_pkg::*;
#(
    parameter int TIME_W = TIME_W_DEF,
    parameter int CAP_W  = CAP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              cfg_wr,
    input  logic              cfg_edge,
    input  edge_evt_t         evt,
    input  logic [TIME_W-1:0] time_lo,
    output logic              cap_ev,
    output logic [CAP_W-1:0]  cap_val
);

    edge_sel_e        sel_q;
    logic             armed_q;
    logic [CAP_W-1:0] cap_q;

    assign cap_ev  = armed_q & edge_match(sel_q, evt);
    assign cap_val = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= EDGE_RISE;
            armed_q <= 1'b0;
            cap_q   <= '0;
        end else begin
            if (cfg_wr) sel_q <= edge_sel_e'(cfg_edge);
            // capture disarms; a simultaneous arm strobe re-arms
            armed_q <= arm_set | (armed_q & ~arm_clr & ~cap_ev);
            if (cap_ev) cap_q <= time_lo[CAP_W-1:0];
        end
    end

    p_value_r2: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> cap_val == $past(time_lo[CAP_W-1:0]));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !cap_ev |=> $stable(cap_val));
    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
        cap_ev && !arm_set |=> !armed_q);
    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        arm_clr && !arm_set |=> !armed_q);

endmodule

// File: rtl/tsc_stat.sv
module tsc_stat (
    input  logic clk,
    input  logic rst,
    input  logic cap_ev,
    input  logic stat_clr,
    input  logic cap_rd,
    input  logic mask_set,
    input  logic mask_clr,
    output logic stat_raw,
    output logic irq
);

    logic raw_q;
    logic mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            raw_q  <= cap_ev | (raw_q & ~stat_clr & ~cap_rd);
            mask_q <= mask_set | (mask_q & ~mask_clr);
        end
    end

    assign stat_raw = raw_q;
    assign irq      = raw_q & mask_q;

    p_set_r8: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> stat_raw);
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        stat_raw && !stat_clr && !cap_rd |=> stat_raw);
    p_clr_r9: assert property (@(posedge clk) disable iff (rst)
        stat_clr && !cap_ev |=> !stat_raw);
    p_rd_r10: assert property (@(posedge clk) disable iff (rst)
        cap_rd && !cap_ev |=> !stat_raw);
    p_race_r11: assert property (@(posedge clk) disable iff (rst)
        cap_ev && (cap_rd || stat_clr) |=> stat_raw);
    p_mask_r12: assert property (@(posedge clk) disable iff (rst)
        mask_clr && !mask_set |=> !irq);

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
    import tsc_pkg::*;
#(
    parameter int TIME_W      = TIME_W_DEF,
    parameter int CAP_W       = CAP_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_in,
    input  logic [TIME_W-1:0] time_lo,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              cfg_wr,
    input  logic              cfg_edge,
    input  logic              stat_clr,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              cap_rd,
    output logic [CAP_W-1:0]  cap_val,
    output logic              stat_raw,
    output logic              irq
);

    edge_evt_t evt;
    logic      cap_ev;

    tsc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cap_in),
        .evt      (evt)
    );

    tsc_arm #(.TIME_W(TIME_W), .CAP_W(CAP_W)) i_arm (
        .clk      (clk),
        .rst      (rst),
        .arm_set  (arm_set),
        .arm_clr  (arm_clr),
        .cfg_wr   (cfg_wr),
        .cfg_edge (cfg_edge),
        .evt      (evt),
        .time_lo  (time_lo),
        .cap_ev   (cap_ev),
        .cap_val  (cap_val)
    );

    tsc_stat i_stat (
        .clk      (clk),
        .rst      (rst),
        .cap_ev   (cap_ev),
        .stat_clr (stat_clr),
        .cap_rd   (cap_rd),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .stat_raw (stat_raw),
        .irq      (irq)
    );

endmodule

// File: tb/test_tstamp_capture.sv
module test_tstamp_capture;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_in = 1'b0;
    logic [31:0] time_lo = 32'hABC1_FFE0;
    logic        arm_set = 0, arm_clr = 0, cfg_wr = 0, cfg_edge = 0;
    logic        stat_clr = 0, mask_set = 0, mask_clr = 0, cap_rd = 0;
    logic [20:0] cap_val;
    logic        stat_raw, irq;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [20:0] exp_cap = '0;
    logic        exp_raw = 1'b0;
    logic        done = 1'b0;

    tstamp_capture i_tstamp_capture (
        .clk(clk), .rst(rst), .cap_in(cap_in), .time_lo(time_lo),
        .arm_set(arm_set), .arm_clr(arm_clr), .cfg_wr(cfg_wr), .cfg_edge(cfg_edge),
        .stat_clr(stat_clr), .mask_set(mask_set), .mask_clr(mask_clr), .cap_rd(cap_rd),
        .cap_val(cap_val), .stat_raw(stat_raw), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // time base moves shortly after each rising edge
    always @(posedge clk) #2 time_lo <= time_lo + 32'd3;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle(input logic lvl);
        cap_in = lvl;
        repeat (4) step();
    endtask

    task automatic do_arm();
        arm_set = 1; step(); arm_set = 0;
    endtask

    task automatic do_unarm_clear();
        arm_clr = 1; stat_clr = 1; step(); arm_clr = 0; stat_clr = 0;
        exp_raw = 0;
    endtask

    task automatic set_edge(input logic e);
        cfg_wr = 1; cfg_edge = e; step(); cfg_wr = 0;
    endtask

    // drives a transition; strobes land in the cycle the capture fires
    task automatic transition(input logic lvl, input logic aclr, input logic rd,
                              input logic iclr, output logic [20:0] sampled);
        cap_in = lvl;
        step();
        step();
        sampled = time_lo[20:0];
        arm_clr = aclr; cap_rd = rd; stat_clr = iclr;
        step();
        arm_clr = 0; cap_rd = 0; stat_clr = 0;
    endtask

    initial begin
        repeat (3 * CLK_PERIOD * 1000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [20:0] s;
        logic        hit;
        repeat (4) step();
        rst = 0;
        step();
        // R1 reset state
        check("R1 cap", cap_val, 0);
        check("R1 raw", stat_raw, 0);
        check("R1 irq", irq, 0);
        transition(1'b1, 0, 0, 0, s);
        step();
        check("R1 unarmed cap", cap_val, 0);
        check("R1 unarmed raw", stat_raw, 0);
        settle(1'b0);

        // sweep: edge select x direction x armed  (R2, R3, R4, R5)
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
                for (int a = 0; a < 2; a++) begin
                    set_edge(e[0]);
                    do_unarm_clear();
                    settle(~d[0]);
                    if (a != 0) do_arm();
                    transition(d[0], 0, 0, 0, s);
                    hit = (a != 0) && (d[0] ^ e[0]);
                    if (hit) begin
                        exp_cap = s;
                        exp_raw = 1;
                    end
                    if (e == 0) begin
                        check("R3 cap", cap_val, exp_cap);
                        check("R3 raw", stat_raw, exp_raw);
                    end else begin
                        check("R4 cap", cap_val, exp_cap);
                        check("R4 raw", stat_raw, exp_raw);
                    end
                    if (hit) begin
                        check("R2 value", cap_val, s);
                        step();
                        check("R8 held", stat_raw, 1);
                        stat_clr = 1; step(); stat_clr = 0;
                        exp_raw = 0;
                        settle(~d[0]);
                        transition(d[0], 0, 0, 0, s);
                        check("R5 held cap", cap_val, exp_cap);
                        check("R5 no status", stat_raw, 0);
                    end
                end
            end
        end

        // coincidence sweep: capture vs arm_clr, cap_rd, stat_clr (R7, R11)
        set_edge(1'b0);
        for (int k = 0; k < 8; k++) begin
            do_unarm_clear();
            settle(1'b0);
            do_arm();
            transition(1'b1, k[0], k[1], k[2], s);
            exp_cap = s;
            exp_raw = 1;
            check("R7 cap", cap_val, exp_cap);
            check("R11 raw", stat_raw, 1);
            stat_clr = 1; step(); stat_clr = 0;
            exp_raw = 0;
            settle(1'b0);
            transition(1'b1, 0, 0, 0, s);
            check("R5 disarmed cap", cap_val, exp_cap);
            check("R5 disarmed raw", stat_raw, 0);
        end

        // R6: arm then disarm, edge ignored
        do_unarm_clear();
        settle(1'b0);
        do_arm();
        arm_clr = 1; step(); arm_clr = 0;
        check("R6 no status", stat_raw, 0);
        transition(1'b1, 0, 0, 0, s);
        check("R6 cap", cap_val, exp_cap);
        check("R6 raw", stat_raw, 0);

        // R9: clear strobe
        settle(1'b0);
        do_arm();
        transition(1'b1, 0, 0, 0, s);
        exp_cap = s;
        check("R8 set", stat_raw, 1);
        stat_clr = 1; step(); stat_clr = 0;
        check("R9 clr", stat_raw, 0);

        // R10: read strobe
        settle(1'b0);
        do_arm();
        transition(1'b1, 0, 0, 0, s);
        exp_cap = s;
        cap_rd = 1; step(); cap_rd = 0;
        check("R10 raw", stat_raw, 0);
        check("R10 cap", cap_val, exp_cap);

        // R12: mask combinations
        settle(1'b0);
        do_arm();
        transition(1'b1, 0, 0, 0, s);
        check("R12 mask0", irq, 0);
        mask_set = 1; step(); mask_set = 0;
        check("R12 mask1", irq, 1);
        mask_clr = 1; step(); mask_clr = 0;
        check("R12 cleared", irq, 0);
        mask_set = 1; mask_clr = 1; step(); mask_set = 0; mask_clr = 0;
        check("R12 set wins", irq, 1);
        stat_clr = 1; step(); stat_clr = 0;
        check("R12 raw0", irq, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule